// File: doc/BRIEF.md
# One-time-fuse array controller

The block controls a one-time-programmable fuse array organised as banks of rows, each row eight fuse bits wide. Software drives it through a simple word-addressed 32-bit register bus. It can blow one selected fuse bit, run an explicit sense cycle that copies a fuse row into a sense-data register and into the row's shadow copy, read shadow rows directly and override shadow rows with new byte values. The fuse array is modelled in flops, and each bank has three protection inputs: read, write (program) and override.

Program and sense are multi-cycle operations. While one runs, the BUSY status bit is high. A completed operation raises a done flag. A refused request raises an error flag. All done and error flags are write-1-to-clear. A single interrupt output combines every flag that its mask bit enables. Programming is refused unless a key register holds 0xAA. The bit to act on is packed across two 8-bit address registers.

Top module: `fuse_ctrl`

Word addresses of the control registers:

| Address | Register |
|---|---|
| 0x0 | STAT |
| 0x1 | STATM |
| 0x2 | ERR |
| 0x3 | EMASK |
| 0x4 | FCTL |
| 0x5 | UA |
| 0x6 | LA |
| 0x7 | SDAT |
| 0xA | KEY |

Address bit 11 set selects the shadow window at 0x800 | bank<<8 | row.

Fields of STAT, ERR and FCTL:

- **STAT:** bit 7 BUSY (read-only), bit 1 program done, bit 0 sense done.
- **ERR:**
  - bit 7 program error
  - bit 6 write-protect error
  - bit 5 override-protect error
  - bit 4 read-protect error
  - bit 3 write-lock error
  - bit 2 sense error
  - bit 1 parity error
- **FCTL:** bit 0 starts a program and bit 3 starts a sense. These two bits always read back as 0. Bits 7:4 and 2:1 are stored and read back.

## Requirements
- R1: After reset every register, including STAT, STATM, ERR, EMASK, FCTL, UA, LA, SDAT and KEY, reads 0. Every shadow row reads 0, and irq_o is low.
- R2: The operation address is formed as follows. Bank comes from UA bits 5:3. Row bits 7:5 come from UA bits 2:0 and row bits 4:0 from LA bits 7:3. The bit index comes from LA bits 2:0.
- R3: Writing FCTL with bit 3 set and bit 0 clear, while idle and with the bank not read-protected, starts a sense. STAT bit 7 then reads 1 for exactly SENSE_CYCLES cycles. After that, STAT bit 0 is set, SDAT holds the fuse row, and the shadow row equals the fuse row.
- R4: Writing FCTL with bit 0 set starts a program when three conditions hold: the block is idle, KEY is 0xAA, and the bank is not write-protected. A program takes priority over a sense requested in the same write. BUSY lasts exactly PROG_CYCLES cycles. Then exactly the addressed fuse bit is set and STAT bit 1 is set. The shadow row stays unchanged until that row is next sensed.
- R5: A program request while KEY is not 0xAA sets ERR bit 7. It does not start BUSY, does not change the fuse and leaves STAT bit 1 clear.
- R6: A program request with the correct key to a write-protected bank sets ERR bit 6. It does not start BUSY, does not change the fuse and leaves STAT bit 1 clear.
- R7: A sense request to a read-protected bank sets ERR bit 2. It does not start BUSY, leaves SDAT unchanged and leaves STAT bit 0 clear.
- R8: A read at 0x800|bank<<8|row returns the shadow byte. If the bank is read-protected, the read returns 0 and sets ERR bit 4.
- R9: A write to the shadow window replaces the shadow byte with wdata bits 7:0. If the bank is override-protected, the write sets ERR bit 5 and the byte is unchanged.
- R10: Start requests written while BUSY is 1 are ignored. The running operation completes on its own address, and no other flag is set.
- R11: Writing 1 to STAT bits 1:0 or ERR bits 7:1 clears those flags. Writing 0 leaves them unchanged.
- R12: irq_o is high exactly when some STAT flag ANDed with its STATM bit is 1, or some ERR flag ANDed with its EMASK bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| prot_rd_i | input | BANKS | Per-bank read protection |
| prot_wr_i | input | BANKS | Per-bank program protection |
| prot_ovr_i | input | BANKS | Per-bank override protection |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with BANKS=4, ROWS=32, SENSE_CYCLES=3 and PROG_CYCLES=4. This keeps the whole array of 128 rows small enough to program and then sense in full, and the busy windows short enough to count cycle by cycle. With this configuration every bank's protection input can be toggled, and the effect of each refused request can be observed on the sense and shadow paths. Each refused request is a bad key, a write-protected program, a read-protected read or sense, or a blocked override.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int ADDR_W = 12;

  localparam logic [3:0] RA_STAT  = 4'h0;
  localparam logic [3:0] RA_STATM = 4'h1;
  localparam logic [3:0] RA_ERR   = 4'h2;
  localparam logic [3:0] RA_EMASK = 4'h3;
  localparam logic [3:0] RA_FCTL  = 4'h4;
  localparam logic [3:0] RA_UA    = 4'h5;
  localparam logic [3:0] RA_LA    = 4'h6;
  localparam logic [3:0] RA_SDAT  = 4'h7;
  localparam logic [3:0] RA_KEY   = 4'hA;

  localparam int ST_BUSY  = 7;
  localparam int ST_PDONE = 1;
  localparam int ST_SDONE = 0;

  localparam int ER_PROG = 7;
  localparam int ER_WP   = 6;
  localparam int ER_OVR  = 5;
  localparam int ER_RD   = 4;
  localparam int ER_SNS  = 2;

  localparam int FC_SNS = 3;
  localparam int FC_PRG = 0;
  localparam logic [7:0] FCTL_KEEP = 8'hF6;

  localparam logic [7:0] PROG_KEY = 8'hAA;
endpackage

// File: rtl/fuse_seq.sv
module fuse_seq #(
  parameter int SENSE_CYCLES = 16,
  parameter int PROG_CYCLES  = 64,
  parameter int IDX_W        = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_sense_i,
  input  logic             start_prog_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [2:0]       bit_i,
  output logic             busy_o,
  output logic             prog_busy_o,
  output logic             fin_sense_o,
  output logic             fin_prog_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [2:0]       bit_o
);
  localparam int MAXC  = (SENSE_CYCLES > PROG_CYCLES) ? SENSE_CYCLES : PROG_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             is_prog_q;
  logic             fin;

  assign busy_o      = cnt_q != '0;
  assign prog_busy_o = busy_o & is_prog_q;
  assign fin         = cnt_q == CNT_W'(1);
  assign fin_sense_o = fin & ~is_prog_q;
  assign fin_prog_o  = fin & is_prog_q;
  assign idx_o       = idx_q;
  assign bit_o       = bit_q;

  logic [IDX_W-1:0] idx_q;
  logic [2:0]       bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      is_prog_q <= 1'b0;
      idx_q     <= '0;
      bit_q     <= '0;
    end else if (!busy_o && (start_prog_i || start_sense_i)) begin
      cnt_q     <= start_prog_i ? CNT_W'(PROG_CYCLES) : CNT_W'(SENSE_CYCLES);
      is_prog_q <= start_prog_i;
      idx_q     <= idx_i;
      bit_q     <= bit_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  AST_FIN_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_sense_o || fin_prog_o) |=> !busy_o); // R3
  AST_ONE_FINISH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fin_sense_o, fin_prog_o})); // R4
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fin) |=> $stable(idx_q) && $stable(bit_q)); // R10
endmodule

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int DEPTH = 2048,
  parameter int IDX_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_en_i,
  input  logic [IDX_W-1:0] prog_idx_i,
  input  logic [2:0]       prog_bit_i,
  input  logic [IDX_W-1:0] fuse_idx_i,
  output logic [7:0]       fuse_row_o,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [IDX_W-1:0] shd_idx_i,
  output logic [7:0]       shd_rdata_o,
  input  logic             shd_we_i,
  input  logic [7:0]       shd_wdata_i
);
  logic [7:0] fuse_q [DEPTH];
  logic [7:0] shd_q  [DEPTH];

  assign fuse_row_o  = fuse_q[fuse_idx_i];
  assign shd_rdata_o = shd_q[shd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) fuse_q[i] <= '0;
    end else if (prog_en_i) begin
      fuse_q[prog_idx_i][prog_bit_i] <= 1'b1;
    end
  end

  // sense reload wins over a bus override of the same row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) shd_q[i] <= '0;
    end else begin
      if (shd_we_i) shd_q[shd_idx_i] <= shd_wdata_i;
      if (ld_en_i)  shd_q[ld_idx_i]  <= fuse_q[ld_idx_i];
    end
  end

  AST_BIT_BLOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_en_i |=> fuse_q[$past(prog_idx_i)][$past(prog_bit_i)]); // R4
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
#(
  parameter int BANKS        = 8,
  parameter int ROWS         = 256,
  parameter int SENSE_CYCLES = 16,
  parameter int PROG_CYCLES  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [BANKS-1:0]  prot_rd_i,
  input  logic [BANKS-1:0]  prot_wr_i,
  input  logic [BANKS-1:0]  prot_ovr_i,
  output logic              irq_o
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int IDX_W  = BANK_W + ROW_W;
  localparam int DEPTH  = BANKS * ROWS;

  logic [1:0] stat_q, statm_q;
  logic [7:1] err_q, emask_q;
  logic [7:0] fctl_q, ua_q, la_q, sdat_q, key_q;

  logic wr, rd, is_shd, is_reg;
  logic [3:0] ra;
  logic [BANK_W-1:0] sbank, obank;
  logic [IDX_W-1:0] sidx, cur_idx, op_idx;
  logic [7:0] row_full, fuse_row, shd_rdata;
  logic [2:0] op_bit;
  logic busy, prog_busy, fin_sense, fin_prog;
  logic fctl_wr, prog_req, sense_req;
  logic prog_key_bad, prog_wp, prog_go, sense_rp, sense_go;
  logic shd_wr, ovr_bad, rd_bad;
  logic [1:0] stat_set, stat_clr;
  logic [7:1] err_set, err_clr;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[31:8];

  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;
  assign is_shd = addr_i[ADDR_W-1];
  assign is_reg = ~is_shd & (addr_i[ADDR_W-2:4] == '0);
  assign ra     = addr_i[3:0];
  assign sbank  = addr_i[8 +: BANK_W];
  assign sidx   = {sbank, addr_i[ROW_W-1:0]};

  assign row_full = {ua_q[2:0], la_q[7:3]};
  assign obank    = ua_q[3 +: BANK_W];
  assign cur_idx  = {obank, row_full[ROW_W-1:0]};

  assign fctl_wr   = wr & is_reg & (ra == RA_FCTL);
  assign prog_req  = fctl_wr & wdata_i[FC_PRG] & ~busy;
  assign sense_req = fctl_wr & wdata_i[FC_SNS] & ~wdata_i[FC_PRG] & ~busy;

  assign prog_key_bad = prog_req & (key_q != PROG_KEY);
  assign prog_wp      = prog_req & (key_q == PROG_KEY) & prot_wr_i[obank];
  assign prog_go      = prog_req & (key_q == PROG_KEY) & ~prot_wr_i[obank];
  assign sense_rp     = sense_req & prot_rd_i[obank];
  assign sense_go     = sense_req & ~prot_rd_i[obank];

  assign shd_wr  = wr & is_shd;
  assign ovr_bad = shd_wr & prot_ovr_i[sbank];
  assign rd_bad  = rd & is_shd & prot_rd_i[sbank];

  fuse_seq #(
    .SENSE_CYCLES(SENSE_CYCLES),
    .PROG_CYCLES (PROG_CYCLES),
    .IDX_W       (IDX_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_sense_i(sense_go),
    .start_prog_i (prog_go),
    .idx_i        (cur_idx),
    .bit_i        (la_q[2:0]),
    .busy_o       (busy),
    .prog_busy_o  (prog_busy),
    .fin_sense_o  (fin_sense),
    .fin_prog_o   (fin_prog),
    .idx_o        (op_idx),
    .bit_o        (op_bit)
  );

  fuse_array #(
    .DEPTH(DEPTH),
    .IDX_W(IDX_W)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prog_en_i  (fin_prog),
    .prog_idx_i (op_idx),
    .prog_bit_i (op_bit),
    .fuse_idx_i (op_idx),
    .fuse_row_o (fuse_row),
    .ld_en_i    (fin_sense),
    .ld_idx_i   (op_idx),
    .shd_idx_i  (sidx),
    .shd_rdata_o(shd_rdata),
    .shd_we_i   (shd_wr & ~prot_ovr_i[sbank]),
    .shd_wdata_i(wdata_i[7:0])
  );

  assign stat_set = {fin_prog, fin_sense};
  assign stat_clr = (wr && is_reg && ra == RA_STAT) ? wdata_i[1:0] : 2'b0;
  assign err_set  = {prog_key_bad, prog_wp, ovr_bad, rd_bad, 1'b0, sense_rp, 1'b0};
  assign err_clr  = (wr && is_reg && ra == RA_ERR) ? wdata_i[7:1] : 7'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      statm_q <= '0;
      err_q   <= '0;
      emask_q <= '0;
      fctl_q  <= '0;
      ua_q    <= '0;
      la_q    <= '0;
      sdat_q  <= '0;
      key_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      err_q  <= (err_q & ~err_clr) | err_set;
      if (fin_sense) sdat_q <= fuse_row;
      if (wr && is_reg) begin
        case (ra)
          RA_STATM: statm_q <= wdata_i[1:0];
          RA_EMASK: emask_q <= wdata_i[7:1];
          RA_FCTL:  fctl_q  <= wdata_i[7:0] & FCTL_KEEP;
          RA_UA:    ua_q    <= {2'b0, wdata_i[5:0]};
          RA_LA:    la_q    <= wdata_i[7:0];
          RA_KEY:   key_q   <= wdata_i[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (is_shd) begin
      if (!prot_rd_i[sbank]) rdata_o[7:0] = shd_rdata;
    end else if (is_reg) begin
      case (ra)
        RA_STAT:  rdata_o[7:0] = {busy, 5'b0, stat_q};
        RA_STATM: rdata_o[7:0] = {6'b0, statm_q};
        RA_ERR:   rdata_o[7:0] = {err_q, 1'b0};
        RA_EMASK: rdata_o[7:0] = {emask_q, 1'b0};
        RA_FCTL:  rdata_o[7:0] = fctl_q;
        RA_UA:    rdata_o[7:0] = ua_q;
        RA_LA:    rdata_o[7:0] = la_q;
        RA_SDAT:  rdata_o[7:0] = sdat_q;
        RA_KEY:   rdata_o[7:0] = key_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = (|(stat_q & statm_q)) | (|(err_q & emask_q));

  AST_KEY_BEFORE_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_busy) |-> $past(key_q) == PROG_KEY); // R5
  AST_WP_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_wp |=> !busy); // R6
  AST_RP_SENSE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_rp |=> err_q[ER_SNS] && !busy); // R7
  AST_RD_PROT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_bad |=> err_q[ER_RD]); // R8
  AST_OVR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_bad |=> err_q[ER_OVR]); // R9
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[ST_PDONE] && !(wr && is_reg && ra == RA_STAT)) |=> stat_q[ST_PDONE]); // R11
endmodule

// File: tb/fuse_ctrl_bench.sv
module fuse_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int NR = 32;
  localparam int SC = 3;
  localparam int PC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NB-1:0] p_rd = '0, p_wr = '0, p_ovr = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [NB*NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_ctrl #(.BANKS(NB), .ROWS(NR), .SENSE_CYCLES(SC), .PROG_CYCLES(PC)) u_fuse_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .prot_rd_i(p_rd), .prot_wr_i(p_wr),
    .prot_ovr_i(p_ovr), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #(CLK_PERIOD/4);
    d = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 40; i++) begin
      rd(12'h0, s);
      if (!s[7]) break;
    end
  endtask

  task automatic set_addr(input int b, input int r, input int bt);
    wr(12'h5, 32'((b << 3) | (r >> 5)));
    wr(12'h6, 32'(((r << 3) | bt) & 8'hFF));
  endtask

  function automatic logic [11:0] shd(input int b, input int r);
    return 12'(12'h800 | (b << 8) | r);
  endfunction

  task automatic prog(input int b, input int r, input int bt);
    set_addr(b, r, bt);
    wr(12'h4, 32'h1);
    wait_idle();
    wr(12'h0, 32'h3);
  endtask

  task automatic sense(input int b, input int r);
    set_addr(b, r, 0);
    wr(12'h4, 32'h8);
    wait_idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] sd;
    for (int i = 0; i < NB*NR; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    foreach (v[i]) ;
    for (int a = 0; a < 11; a++) begin
      if (a == 8 || a == 9) continue;
      rd(12'(a), v);
      chk($sformatf("R1 reg %0d", a), v, 32'h0);
    end
    rd(shd(2, 17), v); chk("R1 shadow", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R4 busy window, R2 packing, shadow not refreshed
    wr(12'hA, 32'hAA);
    set_addr(1, 9, 5);
    wr(12'h4, 32'h1);
    for (int k = 0; k < PC; k++) begin
      rd(12'h0, v); chk("R4 busy during program", v, 32'h80);
    end
    rd(12'h0, v); chk("R4 program done", v, 32'h02);
    model[1*NR+9][5] = 1'b1;
    rd(shd(1, 9), v); chk("R4 shadow stale before sense", v, 0);

    // R11 write-0 keeps, write-1 clears
    wr(12'h0, 32'h0); rd(12'h0, v); chk("R11 write 0 keeps", v, 32'h02);
    wr(12'h0, 32'h2); rd(12'h0, v); chk("R11 write 1 clears", v, 32'h0);

    // R3 sense timing and data
    set_addr(1, 9, 0);
    wr(12'h4, 32'h8);
    for (int k = 0; k < SC; k++) begin
      rd(12'h0, v); chk("R3 busy during sense", v, 32'h80);
    end
    rd(12'h0, v); chk("R3 sense done", v, 32'h01);
    rd(12'h7, v); chk("R3 sdat", v, 32'h20);
    rd(shd(1, 9), v); chk("R3 shadow refreshed", v, 32'h20);
    wr(12'h0, 32'h1);

    // R2 R4 sweep: one bit per row
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++) begin
        prog(b, r, (b + r) & 7);
        model[b*NR+r][(b + r) & 7] = 1'b1;
      end
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++) begin
        sense(b, r);
        rd(12'h7, v); chk($sformatf("R2 sdat b%0d r%0d", b, r), v, {24'b0, model[b*NR+r]});
        rd(shd(b, r), v); chk($sformatf("R3 shadow b%0d r%0d", b, r), v, {24'b0, model[b*NR+r]});
        wr(12'h0, 32'h3);
      end

    // R4 program wins over sense in the same write
    set_addr(0, 1, 7);
    wr(12'h4, 32'h9);
    wait_idle();
    rd(12'h0, v); chk("R4 both bits -> program only", v, 32'h02);
    wr(12'h0, 32'h3);
    model[0*NR+1][7] = 1'b1;
    sense(0, 1); rd(12'h7, v); chk("R4 bit7 blown", v, {24'b0, model[1]});
    wr(12'h0, 32'h3);

    // R10 starts while busy ignored
    set_addr(2, 5, 0);
    wr(12'h4, 32'h1);
    wr(12'h6, 32'(((5 << 3) | 3)));
    wr(12'h4, 32'h1);
    wr(12'h4, 32'h8);
    wait_idle();
    rd(12'h0, v); chk("R10 only program done", v, 32'h02);
    rd(12'h2, v); chk("R10 no error", v, 32'h0);
    wr(12'h0, 32'h3);
    model[2*NR+5][0] = 1'b1;
    sense(2, 5); rd(12'h7, v); chk("R10 only first bit", v, {24'b0, model[2*NR+5]});
    wr(12'h0, 32'h3);

    // R5 wrong key
    wr(12'hA, 32'h55);
    set_addr(3, 7, 1);
    wr(12'h4, 32'h1);
    rd(12'h0, v); chk("R5 no busy no done", v, 32'h0);
    rd(12'h2, v); chk("R5 program error", v, 32'h80);
    wr(12'h2, 32'h80); rd(12'h2, v); chk("R11 err clear", v, 32'h0);
    wr(12'hA, 32'hAA);
    sense(3, 7); rd(12'h7, v); chk("R5 fuse unchanged", v, {24'b0, model[3*NR+7]});
    wr(12'h0, 32'h3);

    // R6 write-protected bank
    p_wr = 4'b0100;
    set_addr(2, 8, 2);
    wr(12'h4, 32'h1);
    rd(12'h0, v); chk("R6 no busy no done", v, 32'h0);
    rd(12'h2, v); chk("R6 write-protect error", v, 32'h40);
    wr(12'h2, 32'hFE);
    p_wr = '0;
    sense(2, 8); rd(12'h7, v); chk("R6 fuse unchanged", v, {24'b0, model[2*NR+8]});
    wr(12'h0, 32'h3);

    // R8 R7 read protection
    rd(12'h7, sd);
    p_rd = 4'b0010;
    rd(shd(1, 3), v); chk("R8 protected read value", v, 0);
    rd(12'h2, v); chk("R8 read-protect error", v, 32'h10);
    wr(12'h2, 32'hFE);
    set_addr(1, 3, 0);
    wr(12'h4, 32'h8);
    rd(12'h0, v); chk("R7 no busy no done", v, 32'h0);
    rd(12'h2, v); chk("R7 sense error", v, 32'h04);
    rd(12'h7, v); chk("R7 sdat unchanged", v, sd);
    wr(12'h2, 32'hFE);
    p_rd = '0;
    rd(shd(1, 3), v); chk("R8 shadow read", v, {24'b0, model[1*NR+3]});
    rd(12'h2, v); chk("R8 no error unprotected", v, 0);

    // R9 override
    wr(shd(3, 4), 32'h5A);
    rd(shd(3, 4), v); chk("R9 override write", v, 32'h5A);
    rd(12'h2, v); chk("R9 no error", v, 0);
    p_ovr = 4'b1000;
    wr(shd(3, 4), 32'hC3);
    rd(shd(3, 4), v); chk("R9 blocked override", v, 32'h5A);
    rd(12'h2, v); chk("R9 override-protect error", v, 32'h20);
    p_ovr = '0;
    sense(3, 4);
    rd(shd(3, 4), v); chk("R3 sense restores shadow", v, {24'b0, model[3*NR+4]});

    // R12 interrupt masking (ERR bit5 and STAT bit0 set now)
    chk("R12 masked off", {31'b0, irq}, 0);
    wr(12'h3, 32'h20); #1 chk("R12 err enabled", {31'b0, irq}, 1);
    wr(12'h2, 32'h20); #1 chk("R12 err cleared", {31'b0, irq}, 0);
    wr(12'h1, 32'h2);  #1 chk("R12 other status bit", {31'b0, irq}, 0);
    wr(12'h1, 32'h1);  #1 chk("R12 sense done enabled", {31'b0, irq}, 1);
    wr(12'h0, 32'h1);  #1 chk("R12 status cleared", {31'b0, irq}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule